// File: doc/BRIEF.md
# Infrared Receive Edge Detector

This block is the receive half of an infrared remote-control port. When reception is switched on, it samples the raw infrared input on each carrier-clock sample tick. It discards level changes that do not last, and keeps a filtered copy of the line that software reads as the received data bit. Each accepted low-to-high or high-to-low change sets its own cause flag. Each cause flag has its own interrupt enable.

Beside the edge logic sits an 8-bit length down-counter that software reloads, typically with 0xFF, from its edge interrupt handler. The counter decrements on a separate length tick. The value software reads at the next edge therefore shows how long the previous level lasted. If no edge arrives before the counter runs out, it stops at zero and raises a third, separately enabled cause. The combined interrupt is the OR of the enabled causes. Decoding of any remote-control protocol is left to software.

Top module: `ir_rx_edge`

## Requirements
- R1: After reset, data_bit, rise_flag, fall_flag, udf_flag and irq are 0 and len_cnt is 0.
- R2: When reception becomes active (cfg_en and cfg_rx_mode both 1), data_bit takes the current synchronized pin level, and no cause flag is set.
- R3: While cfg_en or cfg_rx_mode is 0, pin changes and sample ticks leave data_bit unchanged and set no edge flag.
- R4: A new pin level that is seen on only one sample tick, and is gone by the next sample tick, is treated as noise. data_bit does not change and no flag is set.
- R5: A low-to-high change seen on two consecutive sample ticks is accepted on the second tick. data_bit becomes 1 and rise_flag (cause bit 0) is set in the same cycle.
- R6: A high-to-low change seen on two consecutive sample ticks is accepted on the second tick. data_bit becomes 0 and fall_flag (cause bit 1) is set.
- R7: data_bit changes only when an edge is accepted or when reception starts. A pin change with no sample tick leaves it unchanged.
- R8: A pulse on clr_wr clears every cause flag whose clr_mask bit is 1 (bit 0 rise, bit 1 fall, bit 2 underflow). Flags whose mask bit is 0 keep their value. A cause event in the same cycle wins over the clear.
- R9: irq is 1 exactly when some cause flag is 1 and its bit in ie is 1, using the same bit order as clr_mask.
- R10: A pulse on len_wr loads len_wdata into len_cnt. Each len_tick while reception is active then lowers len_cnt by one.
- R11: When len_cnt steps from 1 to 0, udf_flag (cause bit 2) is set. len_cnt then holds at 0 on further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable |
| cfg_rx_mode | input | 1 | 1 selects receive operation |
| pin_in | input | 1 | Raw infrared input, asynchronous |
| smp_tick | input | 1 | One-cycle carrier-clock sample strobe |
| len_tick | input | 1 | One-cycle length-counter clock strobe |
| len_wr | input | 1 | Load strobe for the length counter |
| len_wdata | input | LEN_W (8) | Value loaded into the length counter |
| clr_wr | input | 1 | Write strobe for clearing cause flags |
| clr_mask | input | 3 | Write-1-to-clear mask: bit 0 rise, bit 1 fall, bit 2 underflow |
| ie | input | 3 | Interrupt enables, same bit order as clr_mask |
| data_bit | output | 1 | Filtered received level |
| rise_flag | output | 1 | Rising-edge cause |
| fall_flag | output | 1 | Falling-edge cause |
| udf_flag | output | 1 | Length-counter underflow cause |
| len_cnt | output | LEN_W (8) | Current length-counter value |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives a single-tick excursion of the pin and confirms it is dropped. A filter that accepts on the first differing sample would flip data_bit and raise a flag here. It also lands a flag clear on the same cycle as an accepted edge. A design that lets the clear win would lose that event. It toggles the pin while the mode bit is 0 and then re-enables reception. A design that keeps filtering while disabled, or that raises an edge on start-up, would show a spurious flag there. On the counter side, it counts down through 1 to 0 and then past it. A counter that wraps to 0xFF, or that misses the underflow cause, shows up at once. The bench also checks each interrupt enable in isolation.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
   localparam int NUM_CAUSES = 3;
   localparam int CAUSE_RISE = 0;
   localparam int CAUSE_FALL = 1;
   localparam int CAUSE_UDF  = 2;
   typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/ir_rx_filter.sv
module ir_rx_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic smp_tick,
   input  logic pin_in,
   output logic level,
   output logic rise_ev,
   output logic fall_ev
);
   localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

   logic pin_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= pin_in;
               for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign pin_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   logic             active_q;
   logic [CNT_W-1:0] run_cnt;
   logic             start;
   logic             differs;
   logic             accept;

   assign start   = active & ~active_q;
   assign differs = pin_s ^ level;
   assign accept  = active & ~start & smp_tick & differs & (run_cnt == LAST);
   assign rise_ev = accept & pin_s;
   assign fall_ev = accept & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         level    <= 1'b0;
         run_cnt  <= '0;
      end else begin
         active_q <= active;
         if (start) begin
            level   <= pin_s;
            run_cnt <= '0;
         end else if (!active) begin
            run_cnt <= '0;
         end else if (smp_tick) begin
            if (accept) begin
               level   <= pin_s;
               run_cnt <= '0;
            end else if (differs) begin
               run_cnt <= run_cnt + 1'b1;
            end else begin
               run_cnt <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/ir_rx_lencnt.sv
module ir_rx_lencnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             len_tick,
   input  logic             wr,
   input  logic [LEN_W-1:0] wdata,
   output logic [LEN_W-1:0] cnt,
   output logic             udf_ev
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic step;
   assign step   = active & len_tick & ~wr & (cnt != '0);
   assign udf_ev = step & (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wr)   cnt <= wdata;
      else if (step) cnt <= cnt - ONE;
   end
endmodule

// File: rtl/ir_rx_causes.sv
module ir_rx_causes
   import ir_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cause_vec_t set_ev,
   input  logic       clr_wr,
   input  cause_vec_t clr_mask,
   input  cause_vec_t ie,
   output cause_vec_t flags,
   output logic       irq
);
   generate
      for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[g] <= 1'b0;
            else if (set_ev[g]) flags[g] <= 1'b1;
            else if (clr_wr && clr_mask[g]) flags[g] <= 1'b0;
         end
      end
   endgenerate

   assign irq = |(flags & ie);
endmodule

// File: rtl/ir_rx_edge.sv
module ir_rx_edge
   import ir_rx_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_rx_mode,
   input  logic             pin_in,
   input  logic             smp_tick,
   input  logic             len_tick,
   input  logic             len_wr,
   input  logic [LEN_W-1:0] len_wdata,
   input  logic             clr_wr,
   input  logic [2:0]       clr_mask,
   input  logic [2:0]       ie,
   output logic             data_bit,
   output logic             rise_flag,
   output logic             fall_flag,
   output logic             udf_flag,
   output logic [LEN_W-1:0] len_cnt,
   output logic             irq
);
   generate
      if (LEN_W < 2)       begin : g_bad_len  $error("LEN_W must be at least 2"); end
      if (FILT_LEN < 1)    begin : g_bad_filt $error("FILT_LEN must be at least 1"); end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic       active;
   logic       rise_ev, fall_ev, udf_ev;
   cause_vec_t set_ev, flags;

   assign active = cfg_en & cfg_rx_mode;

   ir_rx_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filter (
      .clk(clk), .rst_n(rst_n), .active(active), .smp_tick(smp_tick),
      .pin_in(pin_in), .level(data_bit), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   ir_rx_lencnt #(.LEN_W(LEN_W)) u_lencnt (
      .clk(clk), .rst_n(rst_n), .active(active), .len_tick(len_tick),
      .wr(len_wr), .wdata(len_wdata), .cnt(len_cnt), .udf_ev(udf_ev)
   );

   always_comb begin
      set_ev             = '0;
      set_ev[CAUSE_RISE] = rise_ev;
      set_ev[CAUSE_FALL] = fall_ev;
      set_ev[CAUSE_UDF]  = udf_ev;
   end

   ir_rx_causes u_causes (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_wr(clr_wr),
      .clr_mask(clr_mask), .ie(ie), .flags(flags), .irq(irq)
   );

   assign rise_flag = flags[CAUSE_RISE];
   assign fall_flag = flags[CAUSE_FALL];
   assign udf_flag  = flags[CAUSE_UDF];
endmodule

// File: rtl/ir_rx_edge_chk.sv
module ir_rx_edge_chk #(
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             cfg_rx_mode,
   input logic             len_wr,
   input logic             len_tick,
   input logic [2:0]       ie,
   input logic             data_bit,
   input logic             rise_flag,
   input logic             fall_flag,
   input logic             udf_flag,
   input logic [LEN_W-1:0] len_cnt,
   input logic             irq
);
   // R5
   rise_sets_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rise_flag) |-> data_bit);

   // R6
   fall_sets_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fall_flag) |-> !data_bit);

   // R3
   idle_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && cfg_rx_mode) |=> !$rose(rise_flag) && !$rose(fall_flag));

   // R9
   irq_enabled_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_flag && ie[0]) || (fall_flag && ie[1]) || (udf_flag && ie[2])) |-> irq);

   // R9
   irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rise_flag || fall_flag || udf_flag));

   // R10
   cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!len_wr && !len_tick) |=> $stable(len_cnt));

   // R11
   cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_cnt == '0 && !len_wr) |=> len_cnt == '0);

   // R11
   udf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udf_flag) |-> len_cnt == '0);
endmodule

bind ir_rx_edge ir_rx_edge_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rx_mode(cfg_rx_mode),
   .len_wr(len_wr), .len_tick(len_tick), .ie(ie), .data_bit(data_bit),
   .rise_flag(rise_flag), .fall_flag(fall_flag), .udf_flag(udf_flag),
   .len_cnt(len_cnt), .irq(irq)
);

// File: tb/test_ir_rx_edge.sv
`timescale 1ns/1ps
module test_ir_rx_edge;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0, cfg_rx_mode = 1'b0, pin_in = 1'b0;
   logic       smp_tick = 1'b0, len_tick = 1'b0, len_wr = 1'b0, clr_wr = 1'b0;
   logic [7:0] len_wdata = '0;
   logic [2:0] clr_mask = '0, ie = '0;
   logic       data_bit, rise_flag, fall_flag, udf_flag, irq;
   logic [7:0] len_cnt;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   ir_rx_edge i_ir_rx_edge (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rx_mode(cfg_rx_mode),
      .pin_in(pin_in), .smp_tick(smp_tick), .len_tick(len_tick), .len_wr(len_wr),
      .len_wdata(len_wdata), .clr_wr(clr_wr), .clr_mask(clr_mask), .ie(ie),
      .data_bit(data_bit), .rise_flag(rise_flag), .fall_flag(fall_flag),
      .udf_flag(udf_flag), .len_cnt(len_cnt), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(logic v);
      pin_in = v;
      wait_clk(4);
   endtask

   task automatic stick();
      smp_tick = 1'b1;
      @(negedge clk);
      smp_tick = 1'b0;
      wait_clk(1);
   endtask

   task automatic ltick();
      len_tick = 1'b1;
      @(negedge clk);
      len_tick = 1'b0;
   endtask

   task automatic clear(logic [2:0] m);
      clr_mask = m; clr_wr = 1'b1;
      @(negedge clk);
      clr_wr = 1'b0; clr_mask = '0;
   endtask

   task automatic t_reset();
      check("R1 data_bit", data_bit, 0);
      check("R1 flags", {udf_flag, fall_flag, rise_flag}, 0);
      check("R1 len_cnt", len_cnt, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_start();
      set_pin(1'b1);
      cfg_en = 1'b1; cfg_rx_mode = 1'b1;
      wait_clk(2);
      check("R2 data_bit from pin", data_bit, 1);
      check("R2 no flag on start", {udf_flag, fall_flag, rise_flag}, 0);
   endtask

   task automatic t_glitch();
      set_pin(1'b0);
      stick();
      set_pin(1'b1);
      stick();
      stick();
      check("R4 glitch data_bit", data_bit, 1);
      check("R4 glitch flags", {fall_flag, rise_flag}, 0);
   endtask

   task automatic t_fall();
      set_pin(1'b0);
      wait_clk(6);
      check("R7 no tick no change", data_bit, 1);
      stick();
      check("R7 one tick no change", data_bit, 1);
      check("R6 not yet", fall_flag, 0);
      stick();
      check("R6 data_bit low", data_bit, 0);
      check("R6 fall_flag", fall_flag, 1);
      check("R6 rise untouched", rise_flag, 0);
   endtask

   task automatic t_rise();
      set_pin(1'b1);
      stick();
      stick();
      check("R5 data_bit high", data_bit, 1);
      check("R5 rise_flag", rise_flag, 1);
   endtask

   task automatic t_irq();
      ie = 3'b000; wait_clk(1);
      check("R9 irq masked", irq, 0);
      ie = 3'b001; wait_clk(1);
      check("R9 irq rise enable", irq, 1);
      ie = 3'b010; wait_clk(1);
      check("R9 irq fall enable", irq, 1);
      ie = 3'b100; wait_clk(1);
      check("R9 irq udf only, no udf", irq, 0);
      ie = 3'b000;
   endtask

   task automatic t_clear();
      clear(3'b001);
      check("R8 rise cleared", rise_flag, 0);
      check("R8 fall kept", fall_flag, 1);
      clear(3'b010);
      check("R8 fall cleared", fall_flag, 0);
      // set beats clear: fall pending, clear rise+fall on accepting tick
      set_pin(1'b0);
      stick();
      clr_mask = 3'b011; clr_wr = 1'b1; smp_tick = 1'b1;
      @(negedge clk);
      clr_wr = 1'b0; clr_mask = '0; smp_tick = 1'b0;
      check("R8 set wins over clear", fall_flag, 1);
      clear(3'b010);
   endtask

   task automatic t_disabled();
      cfg_rx_mode = 1'b0;
      wait_clk(1);
      set_pin(1'b1);
      stick(); stick(); stick();
      check("R3 data_bit held", data_bit, 0);
      check("R3 no flags", {fall_flag, rise_flag}, 0);
      cfg_rx_mode = 1'b1;
      wait_clk(2);
      check("R2 restart takes pin", data_bit, 1);
      check("R2 restart no flag", {fall_flag, rise_flag}, 0);
   endtask

   task automatic t_counter();
      len_wdata = 8'd5; len_wr = 1'b1;
      @(negedge clk);
      len_wr = 1'b0;
      check("R10 load", len_cnt, 5);
      ltick(); ltick(); ltick();
      check("R10 three ticks", len_cnt, 2);
      ltick();
      check("R11 at one no udf", udf_flag, 0);
      ltick();
      check("R11 reached zero", len_cnt, 0);
      check("R11 udf_flag", udf_flag, 1);
      ltick(); ltick();
      check("R11 holds at zero", len_cnt, 0);
      ie = 3'b100; wait_clk(1);
      check("R9 irq udf", irq, 1);
      ie = 3'b000;
      clear(3'b100);
      check("R8 udf cleared", udf_flag, 0);
      len_wdata = 8'hFF; len_wr = 1'b1;
      @(negedge clk);
      len_wr = 1'b0;
      ltick(); ltick();
      check("R10 0xFF countdown", len_cnt, 8'hFD);
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(1);
      t_reset();
      t_start();
      t_glitch();
      t_fall();
      t_rise();
      t_irq();
      t_clear();
      t_disabled();
      t_counter();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule